// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Aggregator

This block gathers 32 peripheral interrupt sources into one secondary controller. It has its own status and mask registers. Each source is first brought into the clock domain by a synchroniser. Three fixed sources (bits 16, 22 and 28) are edge sources: a rising edge latches a status bit, and that bit stays set until software writes the status register with the bit at zero. Every other status bit follows its synchronised input level, and writes do not change it.

The status bits that are both pending and enabled are folded into three summary lines, one for each range of sources. These lines feed the primary interrupt controller. Sources 0 to 7 form the audio group, sources 8 to 15 the miscellaneous group, and sources 16 to 31 the serial/parallel group. For cascade decoding, the block also reports the lowest-numbered pending and enabled source. The register port is a plain synchronous write with a combinational read. It has no flow control, because every access completes in one cycle.

Top module: `irq_group_agg`

## Requirements
- R1: While `rst_n` is low, the status register, the mask register, all summary lines, `src_valid` and `src_id` are zero.
- R2: A level status bit (any bit other than 16, 22 and 28) shows the level of its source input three rising clock edges after the input changes. It is not visible after only two edges. Writes to the status register leave level bits unchanged.
- R3: An edge status bit (16, 22 or 28) sets on a rising edge of its synchronised input. It stays set after the input returns low.
- R4: A status write (`reg_sel`=0) with an edge bit at 0 clears that bit on the next edge. A write with the bit at 1 leaves it as it is.
- R5: A new rising edge on an edge source in the same cycle as a write that clears that source's bit leaves the bit set.
- R6: A mask write (`reg_sel`=1) replaces the whole mask register. `reg_rdata` returns the status register when `reg_sel`=0 and the mask register when `reg_sel`=1.
- R7: `sum_irq[2]` is high when some bit 0..7 is pending and enabled. `sum_irq[1]` does the same for bits 8..15 and `sum_irq[0]` for bits 16..31. These lines correspond to primary bits 6, 5 and 4.
- R8: A summary line stays low while its group has no bit set in the mask, whatever the status bits are.
- R9: When any bit is both pending and enabled, `src_valid` is high and `src_id` is the index of the lowest such bit.
- R10: When no bit is both pending and enabled, `src_valid` is low and `src_id` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw peripheral interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sum_irq | output | 3 | Group summary lines: [2] audio, [1] misc, [0] serial/parallel |
| src_valid | output | 1 | Some source is pending and enabled |
| src_id | output | 5 | Lowest pending and enabled source index |

## Verification
The hardest state to reach is a new rising edge on an edge source that lands in exactly the same cycle as a status write that clears it. The stimulus gets there by first latching the bit and dropping the input. It then raises the input again and holds the clearing write until the second edge after that, which is when the synchronised rising edge reaches the status register. Random phases hold each input pattern stable for several cycles before they mix in random mask and status writes. A bench model can then track latched edge bits from the input history alone.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int MAXSRC = 64;

  // Bit mask with ones from lo to hi inclusive.
  function automatic logic [MAXSRC-1:0] span_mask(int lo, int hi);
    logic [MAXSRC-1:0] m;
    m = '0;
    for (int i = 0; i < MAXSRC; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_input_sync.sv
module irq_input_sync #(
  parameter int NSRC   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] din,
  output logic [NSRC-1:0] lvl,
  output logic [NSRC-1:0] rise
);
  logic [STAGES-1:0][NSRC-1:0] chain_q;
  logic [NSRC-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= din;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int              NSRC      = 32,
  parameter logic [NSRC-1:0] EDGE_BITS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] rise,
  input  logic            stat_wr,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (EDGE_BITS[i])
          // a fresh edge wins over a clearing write
          stat_q[i] <= (stat_q[i] & ~(stat_wr & ~wdata[i])) | rise[i];
        else
          stat_q[i] <= lvl[i];
      end
      if (mask_wr) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_group_sum.sv
module irq_group_sum
  import irq_agg_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int LO   = 0,
  parameter int HI   = 7
) (
  input  logic [NSRC-1:0] pend,
  output logic            hit
);
  localparam logic [MAXSRC-1:0] WIDE = span_mask(LO, HI);
  localparam logic [NSRC-1:0]   SEL  = WIDE[NSRC-1:0];

  assign hit = |(pend & SEL);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NSRC = 32,
  parameter int IDW  = 5
) (
  input  logic [NSRC-1:0] req,
  output logic            valid,
  output logic [IDW-1:0]  id
);
  always_comb begin
    id = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) id = IDW'(i);
  end
  assign valid = |req;
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg #(
  parameter int              NSRC      = 32,
  parameter logic [NSRC-1:0] EDGE_BITS = 32'h1041_0000,
  parameter int              SYNC_STG  = 2,
  parameter int              AUD_LO    = 0,
  parameter int              AUD_HI    = 7,
  parameter int              MISC_LO   = 8,
  parameter int              MISC_HI   = 15,
  parameter int              SP_LO     = 16,
  parameter int              SP_HI     = 31,
  localparam int             IDW       = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic [2:0]      sum_irq,
  output logic            src_valid,
  output logic [IDW-1:0]  src_id
);
  logic [NSRC-1:0] lvl_w, rise_w, stat_w, mask_w, pend_w;

  irq_input_sync #(.NSRC(NSRC), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(src_in), .lvl(lvl_w), .rise(rise_w)
  );

  irq_status_bank #(.NSRC(NSRC), .EDGE_BITS(EDGE_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .rise(rise_w),
    .stat_wr(reg_wr & ~reg_sel), .mask_wr(reg_wr & reg_sel),
    .wdata(reg_wdata), .stat_q(stat_w), .mask_q(mask_w)
  );

  assign pend_w    = stat_w & mask_w;
  assign reg_rdata = reg_sel ? mask_w : stat_w;

  // index 0 -> serial/parallel, 1 -> misc, 2 -> audio
  for (genvar g = 0; g < 3; g++) begin : g_grp
    localparam int LO = (g == 0) ? SP_LO : (g == 1) ? MISC_LO : AUD_LO;
    localparam int HI = (g == 0) ? SP_HI : (g == 1) ? MISC_HI : AUD_HI;
    irq_group_sum #(.NSRC(NSRC), .LO(LO), .HI(HI)) u_sum (
      .pend(pend_w), .hit(sum_irq[g])
    );
  end

  irq_lowest_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
    .req(pend_w), .valid(src_valid), .id(src_id)
  );
endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int              NSRC      = 32,
  parameter logic [NSRC-1:0] EDGE_BITS = 32'h1041_0000,
  parameter int              AUD_LO    = 0,
  parameter int              AUD_HI    = 7,
  parameter int              MISC_LO   = 8,
  parameter int              MISC_HI   = 15,
  parameter int              SP_LO     = 16,
  parameter int              SP_HI     = 31,
  localparam int             IDW       = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_sel,
  input logic [NSRC-1:0] reg_wdata,
  input logic [NSRC-1:0] lvl_w,
  input logic [NSRC-1:0] rise_w,
  input logic [NSRC-1:0] stat_w,
  input logic [NSRC-1:0] mask_w,
  input logic [2:0]      sum_irq,
  input logic            src_valid,
  input logic [IDW-1:0]  src_id
);
  localparam logic [MAXSRC-1:0] AUDW = span_mask(AUD_LO, AUD_HI);
  localparam logic [MAXSRC-1:0] MISW = span_mask(MISC_LO, MISC_HI);
  localparam logic [MAXSRC-1:0] SPW  = span_mask(SP_LO, SP_HI);
  localparam logic [NSRC-1:0]   AUDM = AUDW[NSRC-1:0];
  localparam logic [NSRC-1:0]   MISM = MISW[NSRC-1:0];
  localparam logic [NSRC-1:0]   SPM  = SPW[NSRC-1:0];

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] below;
  assign pend  = stat_w & mask_w;
  assign below = (NSRC'(1) << src_id) - NSRC'(1);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (stat_w == '0 && mask_w == '0 && sum_irq == 3'b000 && !src_valid));

  a_r6_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> mask_w == $past(reg_wdata));

  a_r7_audio_line: assert property (@(posedge clk) disable iff (!rst_n)
    sum_irq[2] == |(pend & AUDM));

  a_r8_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_irq[0] |-> |(mask_w & SPM)) and (sum_irq[1] |-> |(mask_w & MISM))
    and (sum_irq[2] |-> |(mask_w & AUDM)));

  a_r9_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> (pend[src_id] && (pend & below) == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |-> (src_id == '0 && pend == '0));

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (EDGE_BITS[i]) begin : g_edge
      a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[i] && !(reg_wr && !reg_sel)) |=> stat_w[i]);
      a_r4_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !reg_wdata[i] && !rise_w[i]) |=> !stat_w[i]);
      a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w[i] |=> stat_w[i]);
    end else begin : g_lvl
      a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_w[i] == $past(lvl_w[i]));
    end
  end
endmodule

bind irq_group_agg irq_group_agg_chk #(
  .NSRC(NSRC), .EDGE_BITS(EDGE_BITS), .AUD_LO(AUD_LO), .AUD_HI(AUD_HI),
  .MISC_LO(MISC_LO), .MISC_HI(MISC_HI), .SP_LO(SP_LO), .SP_HI(SP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .lvl_w(lvl_w), .rise_w(rise_w), .stat_w(stat_w),
  .mask_w(mask_w), .sum_irq(sum_irq), .src_valid(src_valid), .src_id(src_id)
);

// File: tb/irq_group_agg_test.sv
module irq_group_agg_test;
  localparam logic [31:0] EDGE = 32'h1041_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  sum_irq;
  logic        src_valid;
  logic [4:0]  src_id;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [31:0] exp_e = '0;   // latched edge bits
  logic [31:0] exp_m = '0;   // mask

  always #10 clk = ~clk;

  irq_group_agg uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sum_irq(sum_irq), .src_valid(src_valid), .src_id(src_id)
  );

  function automatic logic [2:0] f_sum(logic [31:0] p);
    return {|p[7:0], |p[15:8], |p[31:16]};
  endfunction

  function automatic logic [4:0] f_id(logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    if (sel) exp_m = d;
    else exp_e = exp_e & d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk);
    exp_e = exp_e | (v & ~src_in & EDGE);
    src_in = v;
    cyc(4);
  endtask

  task automatic read(logic sel, output logic [31:0] v);
    reg_sel = sel;
    #2;
    v = reg_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] es, rs, rm, p;
    es = (src_in & ~EDGE) | exp_e;
    p  = es & exp_m;
    read(1'b0, rs);
    chk({tag, " R2/R3 status"}, rs, es);
    read(1'b1, rm);
    chk({tag, " R6 mask"}, rm, exp_m);
    chk({tag, " R7 sum"}, 32'(sum_irq), 32'(f_sum(p)));
    chk({tag, " R9 valid"}, 32'(src_valid), 32'(|p));
    chk({tag, " R9/R10 id"}, 32'(src_id), 32'(f_id(p)));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    src_in = 32'hFFFF_FFFF;
    cyc(3);
    // R1: reset holds everything clear even with inputs high
    read(1'b0, v); chk("R1 status in reset", v, 32'h0);
    read(1'b1, v); chk("R1 mask in reset", v, 32'h0);
    chk("R1 outputs in reset", {27'd0, sum_irq, src_valid, |src_id}, 32'h0);
    src_in = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);

    // R10: nothing pending
    wr(1'b1, 32'hFFFF_FFFF);
    check_all("R10 idle");
    chk("R10 id zero", 32'(src_id), 32'd0);

    // R2: level latency and ignored writes
    @(negedge clk);
    src_in = 32'h0000_0F0F;
    cyc(2); read(1'b0, v);
    chk("R2 not yet after two edges", v, 32'h0);
    cyc(1); read(1'b0, v);
    chk("R2 visible after three edges", v, 32'h0000_0F0F);
    wr(1'b0, 32'h0);
    read(1'b0, v);
    chk("R2 level write ignored", v, 32'h0000_0F0F);
    check_all("R2/R9 lowest=0");

    // R8: no mask in a group keeps its line low
    wr(1'b1, 32'h0000_0100);
    chk("R8 audio line off without mask", 32'(sum_irq[2]), 32'd0);
    chk("R7 misc line", 32'(sum_irq), 32'b010);
    chk("R9 id=8", 32'(src_id), 32'd8);
    wr(1'b1, 32'h0);
    chk("R8 all lines off", 32'(sum_irq), 32'd0);

    // R3: edge latch holds after input falls
    wr(1'b1, 32'hFFFF_FFFF);
    drive(32'h0001_0000);
    drive(32'h0000_0000);
    read(1'b0, v);
    chk("R3 bit16 held", v, 32'h0001_0000);
    chk("R7 serial line", 32'(sum_irq), 32'b001);
    chk("R9 id=16", 32'(src_id), 32'd16);

    // R4: write with 1 keeps, with 0 clears
    wr(1'b0, 32'hFFFF_FFFF);
    read(1'b0, v); chk("R4 write-one keeps", v, 32'h0001_0000);
    wr(1'b0, 32'hFFFE_FFFF);
    read(1'b0, v); chk("R4 write-zero clears", v, 32'h0);

    // R5: edge coincident with clearing write
    drive(32'h0040_0000);               // latch bit 22
    drive(32'h0000_0000);               // input low, bit still latched
    @(negedge clk); src_in = 32'h0040_0000;
    @(negedge clk);                      // after first edge
    @(negedge clk);                      // after second edge
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0;
    @(negedge clk);                      // third edge: rise meets clear
    reg_wr = 1'b0;
    read(1'b0, v);
    chk("R5 edge beats clear", v, 32'h0040_0000);
    exp_e = 32'h0040_0000;
    cyc(2);
    check_all("R5 settle");

    // R9: lowest of several
    drive(32'h0010_0020);
    check_all("R9 multi");
    chk("R9 id=5", 32'(src_id), 32'd5);

    // random phase
    for (int it = 0; it < 80; it++) begin
      if (($urandom % 3) == 0) wr(1'b1, $urandom);
      drive($urandom & (($urandom % 2) ? 32'hFFFF_FFFF : 32'h1041_00FF));
      check_all("rand pre");
      if (($urandom % 2) == 0) begin
        wr(1'b0, $urandom);
        check_all("rand R4 write");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule